// File: doc/BRIEF.md
# Triggered One-Shot Interval Timer

This block counts a programmed number of enabled clock cycles after a trigger and then gives a one-cycle completion pulse. The trigger can be a single go line. It can also be a chain of arming stages, where each line of the go vector must be seen in turn, from the highest index down to bit 0, before the count begins. The interval value is sampled when the trigger completes, so the source that supplies it is free to change while the count runs.

The counter value is visible at all times. A parameter sets whether it runs upward from zero or downward from interval-1. After completion the counter holds its last value until the next trigger, which lets software or nearby logic see where the count ended. All state changes on the rising clock edge. A synchronous reset overrides everything. A completed trigger overrides the enable. A low enable freezes a count that is in progress.

Top module: `ivt_timer`

## Requirements
- R1: When a trigger completes on edge E with a nonzero interval I, busy is high after E, and done is high for exactly one cycle after edge E+I (when enable stays high). Busy is low whenever done is high.
- R2: The interval is sampled only on the edge where the trigger completes. Later changes to the interval input do not change when done occurs or the value of the final counter.
- R3: When a trigger completes with interval zero, done is high for one cycle right after that edge, busy stays low, and the counter keeps its previous value.
- R4: With the up direction, the counter is loaded with 0 on the trigger edge, rises by one on each enabled edge, and holds I-1 from the done pulse until the next trigger.
- R5: With the down direction, the counter is loaded with I-1 on the trigger edge, falls by one on each enabled edge, and holds 0 from the done pulse onward.
- R6: While enable is low, a running count keeps its counter value and busy level, and no done occurs. Each low-enable edge delays done by one cycle. A trigger that completes while enable is low still starts the count.
- R7: A trigger that completes during a running count restarts it with the new interval, and the earlier count never produces done.
- R8: A synchronous reset forces busy, done, the counter and the arming state to 0. It takes precedence over a trigger on the same edge.
- R9: With ARM_STAGES = N > 1, go[N-1] down to go[0] must each be seen in that order. trig_state reports how many stages are armed, and it increases by one for each expected bit. A go bit other than the one awaited has no effect. The go[0] event that completes the chain starts the count and returns trig_state to 0.
- R10: An interval of 2^CNT_W is accepted. Done occurs 2^CNT_W edges after the trigger, and the counter ends at all ones (up direction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes a running count |
| go | input | ARM_STAGES | Trigger vector; the highest index arms first, bit 0 completes |
| interval | input | CNT_W+1 | Number of enabled cycles to count, 0 to 2^CNT_W |
| busy | output | 1 | A count is in progress |
| done | output | 1 | One-cycle completion pulse |
| trig_state | output | $clog2(ARM_STAGES+1) | Number of arming stages already seen |
| ctr | output | CNT_W | Live counter value |

## Verification
Assertions check the following on every cycle: busy and done are never high together; a nonzero trigger raises busy and a zero trigger raises done on the next edge; the counter and busy stay put while enable is low or the timer is idle; an upward count never passes its latched end value; the arming state grows only one step at a time and clears after it fires; and reset always leaves everything idle. Some behaviour needs a bench scenario to show it. This includes the exact cycle of each done pulse and the counter value held there, independence from later changes to the interval, the loss of a done that a restart cancels, reset winning over go on the same edge, and the rejection of out-of-order go bits.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Selects the counting direction of the interval counter.
    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/ivt_arm_seq.sv
// Ordered arming chain: go[STAGES-1] first, go[0] last and firing.
module ivt_arm_seq #(
    parameter int STAGES = 1,
    parameter int ST_W   = $clog2(STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] go,
    output logic              fire_o,
    output logic [ST_W-1:0]   armed_o
);

    localparam logic [ST_W-1:0] LAST_ST = ST_W'(STAGES - 1);

    typedef struct packed {
        logic [ST_W-1:0] armed;
    } seq_t;

    seq_t seq_q, seq_d;
    logic step_hit;
    logic fire_d;

    // Select the go bit awaited at the current arming level.
    always_comb begin
        step_hit = 1'b0;
        for (int k = 0; k < STAGES; k++) begin
            if (int'(seq_q.armed) == STAGES - 1 - k) begin
                step_hit = go[k];
            end
        end
    end

    always_comb begin
        seq_d  = seq_q;
        fire_d = 1'b0;
        if (step_hit) begin
            if (seq_q.armed == LAST_ST) begin
                fire_d      = 1'b1;
                seq_d.armed = '0;
            end else begin
                seq_d.armed = seq_q.armed + ST_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fire_o  = fire_d;
    assign armed_o = seq_q.armed;

    AST_ARM_RANGE: assert property (@(posedge clk) disable iff (rst)
        seq_q.armed <= LAST_ST); // R9

    AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (armed_o == '0)); // R9

    AST_ARM_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (armed_o != $past(armed_o)) |-> ((armed_o == '0) || (armed_o == ST_W'($past(armed_o) + ST_W'(1))))); // R9

endmodule

// File: rtl/ivt_count_core.sv
// Interval counter: loads on start, steps on enabled cycles, pulses done at the end.
module ivt_count_core
    import ivt_pkg::*;
#(
    parameter int       CW  = 32,
    parameter cnt_dir_e DIR = CNT_UP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          start,
    input  logic [CW:0]   interval,
    output logic          busy_o,
    output logic          done_o,
    output logic [CW-1:0] ctr_o
);

    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] ctr;
        logic [CW-1:0] last;
    } core_t;

    core_t core_q, core_d;

    logic          iv_zero;
    logic [CW-1:0] iv_last;
    logic [CW-1:0] load_val;
    logic [CW-1:0] step_val;
    logic          at_end;

    assign iv_zero = (interval == '0);
    assign iv_last = CW'(interval - (CW + 1)'(1));

    generate
        if (DIR == CNT_DOWN) begin : g_down
            assign load_val = iv_last;
            assign step_val = core_q.ctr - ONE_C;
            assign at_end   = (core_q.ctr == '0);
        end else begin : g_up
            assign load_val = '0;
            assign step_val = core_q.ctr + ONE_C;
            assign at_end   = (core_q.ctr == core_q.last);

            AST_UP_BOUND: assert property (@(posedge clk) disable iff (rst)
                core_q.busy |-> (core_q.ctr <= core_q.last)); // R4
        end
    endgenerate

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        if (start) begin
            if (iv_zero) begin
                core_d.busy = 1'b0;
                core_d.done = 1'b1;
            end else begin
                core_d.busy = 1'b1;
                core_d.ctr  = load_val;
                core_d.last = iv_last;
            end
        end else if (en && core_q.busy) begin
            if (at_end) begin
                core_d.busy = 1'b0;
                core_d.done = 1'b1;
            end else begin
                core_d.ctr = step_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign busy_o = core_q.busy;
    assign done_o = core_q.done;
    assign ctr_o  = core_q.ctr;

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o)); // R1

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (start && !iv_zero) |=> (busy_o && !done_o)); // R1

    AST_ZERO_ECHO: assert property (@(posedge clk) disable iff (rst)
        (start && iv_zero) |=> (done_o && !busy_o)); // R3

    AST_EN_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !en && !start) |=> ($stable(ctr_o) && busy_o && !done_o)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start) |=> $stable(ctr_o)); // R4

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int       CNT_W      = 32,
    parameter int       ARM_STAGES = 1,
    parameter cnt_dir_e DIR        = CNT_UP
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                en,
    input  logic [ARM_STAGES-1:0]               go,
    input  logic [CNT_W:0]                      interval,
    output logic                                busy,
    output logic                                done,
    output logic [$clog2(ARM_STAGES+1)-1:0]     trig_state,
    output logic [CNT_W-1:0]                    ctr
);

    localparam int ST_W = $clog2(ARM_STAGES + 1);

    logic fire;

    ivt_arm_seq #(
        .STAGES (ARM_STAGES),
        .ST_W   (ST_W)
    ) u_arm (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .fire_o  (fire),
        .armed_o (trig_state)
    );

    ivt_count_core #(
        .CW  (CNT_W),
        .DIR (DIR)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .start    (fire),
        .interval (interval),
        .busy_o   (busy),
        .done_o   (done),
        .ctr_o    (ctr)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!busy && !done && (trig_state == '0) && (ctr == '0))); // R8

endmodule

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;
    import ivt_pkg::*;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b1;
    logic [0:0]   go  = '0;
    logic [2:0]   go_dn = '0;
    logic [W:0]   interval = '0;

    logic         busy, done;
    logic [0:0]   trig;
    logic [W-1:0] ctr;
    logic         busy_dn, done_dn;
    logic [1:0]   trig_dn;
    logic [W-1:0] ctr_dn;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    at_cyc;
        int    fin_ctr;
        bit    use_ctr;
        string req;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ivt_timer #(.CNT_W(W), .ARM_STAGES(1), .DIR(CNT_UP)) dut_i (
        .clk(clk), .rst(rst), .en(en), .go(go), .interval(interval),
        .busy(busy), .done(done), .trig_state(trig), .ctr(ctr)
    );

    ivt_timer #(.CNT_W(W), .ARM_STAGES(3), .DIR(CNT_DOWN)) dut_dn_i (
        .clk(clk), .rst(rst), .en(en), .go(go_dn), .interval(interval),
        .busy(busy_dn), .done(done_dn), .trig_state(trig_dn), .ctr(ctr_dn)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: every done pulse of the up timer must match the queue head.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7/R8", "unexpected done at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(cyc == e.at_cyc, e.req, "done cycle", cyc, e.at_cyc);
                if (e.use_ctr) chk(ctr == W'(e.fin_ctr), e.req, "final ctr", ctr, e.fin_ctr);
                chk(busy == 1'b0, "R1", "busy during done", busy, 0);
            end
        end
    end

    task automatic wait_drain(input int limit, input string req);
        for (int k = 0; k < limit && sb_q.size() != 0; k++) tick();
        tick();
        if (sb_q.size() != 0) begin
            chk(1'b0, req, "missing done, pending items", sb_q.size(), 0);
            sb_q.delete();
        end
    endtask

    // Driver: one trigger with interval iv, enable low for the trigger edge
    // plus stall edges, interval input changed to late_iv after the trigger.
    task automatic run_up(input int iv, input int stall, input int late_iv, input string req);
        exp_t e;
        tick();
        interval = (W + 1)'(iv);
        go       = 1'b1;
        if (stall > 0) en = 1'b0;
        e.at_cyc  = (iv == 0) ? cyc + 1 : cyc + 1 + stall + iv;
        e.fin_ctr = iv - 1;
        e.use_ctr = (iv != 0);
        e.req     = req;
        sb_q.push_back(e);
        tick();
        go       = 1'b0;
        interval = (W + 1)'(late_iv); // R2: must not matter
        if (stall > 0) begin
            chk(busy == 1'b1, "R6", "busy after trigger with en low", busy, 1);
            chk(ctr == '0, "R6", "ctr after trigger with en low", ctr, 0);
            repeat (stall) tick();
            chk(busy == 1'b1, "R6", "busy frozen", busy, 1);
            chk(ctr == '0, "R6", "ctr frozen", ctr, 0);
            en = 1'b1;
        end
        wait_drain(iv + stall + 10, req);
        if (iv != 0) begin
            repeat (2) tick();
            chk(ctr == W'(iv - 1), "R4", "held final ctr", ctr, iv - 1);
            chk(busy == 1'b0, "R4", "idle after done", busy, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired, cycles", cyc, 150000);
        finish_up();
    end

    initial begin
        repeat (3) tick();
        chk(busy == 0 && done == 0, "R8", "reset busy/done", {busy, done}, 0);
        chk(ctr == 0 && trig == 0, "R8", "reset ctr/trig", ctr, 0);
        chk(trig_dn == 0 && ctr_dn == 0, "R8", "reset dn trig/ctr", trig_dn, 0);
        rst = 1'b0;

        run_up(6, 0, 200, "R1");
        run_up(1, 0, 0, "R1");
        run_up(0, 0, 7, "R3");
        run_up(9, 3, 1, "R6");
        run_up(256, 0, 3, "R10");

        // R3: zero interval keeps previous counter value (255 from R10 run)
        chk(ctr == 8'd255, "R3", "ctr before zero run", ctr, 255);
        run_up(0, 0, 0, "R3");
        chk(ctr == 8'd255, "R3", "ctr unchanged by zero interval", ctr, 255);

        // R7: restart while busy; only the second run reports
        begin
            exp_t e;
            tick();
            interval = 9'd10; go = 1'b1;
            tick(); go = 1'b0;
            repeat (2) tick();
            chk(ctr == 8'd2, "R4", "ctr stepping", ctr, 2);
            interval = 9'd4; go = 1'b1;
            e.at_cyc = cyc + 1 + 4; e.fin_ctr = 3; e.use_ctr = 1'b1; e.req = "R7";
            sb_q.push_back(e);
            tick(); go = 1'b0;
            chk(ctr == 8'd0, "R7", "ctr reloaded on restart", ctr, 0);
            wait_drain(30, "R7");
            repeat (12) tick();
        end

        // R8: reset mid-count, with go on the same edge
        tick();
        interval = 9'd20; go = 1'b1;
        tick(); go = 1'b0;
        repeat (5) tick();
        rst = 1'b1; go = 1'b1;
        tick();
        rst = 1'b0; go = 1'b0;
        chk(busy == 1'b0, "R8", "busy after reset over go", busy, 0);
        chk(ctr == '0, "R8", "ctr after reset", ctr, 0);
        repeat (30) tick();
        chk(busy == 1'b0, "R8", "still idle after reset", busy, 0);

        // R9 / R5: three-stage arming chain on the down timer
        interval = 9'd6;
        go_dn = 3'b001; tick(); go_dn = 3'b000; tick();
        chk(trig_dn == 2'd0 && busy_dn == 0, "R9", "out-of-order go[0] ignored", trig_dn, 0);
        go_dn = 3'b100; tick(); go_dn = 3'b000;
        chk(trig_dn == 2'd1, "R9", "stage 2 armed", trig_dn, 1);
        go_dn = 3'b001; tick(); go_dn = 3'b000;
        chk(trig_dn == 2'd1 && busy_dn == 0, "R9", "early go[0] ignored", trig_dn, 1);
        go_dn = 3'b010; tick(); go_dn = 3'b000;
        chk(trig_dn == 2'd2, "R9", "stage 1 armed", trig_dn, 2);
        go_dn = 3'b001; tick(); go_dn = 3'b000;
        chk(trig_dn == 2'd0, "R9", "chain cleared on fire", trig_dn, 0);
        chk(busy_dn == 1'b1, "R9", "count started", busy_dn, 1);
        chk(ctr_dn == 8'd5, "R5", "down load I-1", ctr_dn, 5);
        interval = 9'd77;
        repeat (5) tick();
        chk(ctr_dn == 8'd0 && done_dn == 0, "R5", "down reaches 0 before done", ctr_dn, 0);
        tick();
        chk(done_dn == 1'b1 && busy_dn == 0, "R5", "down done pulse", done_dn, 1);
        chk(ctr_dn == 8'd0, "R5", "down final ctr", ctr_dn, 0);
        tick();
        chk(done_dn == 1'b0 && ctr_dn == 8'd0, "R5", "down done single, ctr held", done_dn, 0);

        // R3 on the chained timer: zero interval echoes the chain output
        interval = 9'd0;
        go_dn = 3'b100; tick(); go_dn = 3'b010; tick(); go_dn = 3'b001; tick(); go_dn = 3'b000;
        chk(done_dn == 1'b1 && busy_dn == 0, "R3", "zero interval echo", done_dn, 1);
        chk(trig_dn == 2'd0, "R9", "chain cleared after zero fire", trig_dn, 0);
        tick();
        chk(done_dn == 1'b0, "R3", "echo is one cycle", done_dn, 0);

        repeat (3) tick();
        chk(sb_q.size() == 0, "R1", "scoreboard empty", sb_q.size(), 0);
        finish_up();
    end

endmodule